// File: doc/BRIEF.md
# Hot-Plug Interrupt Locator

This block collects the event state of a row of hot-plug slots, plus a command-completion flag from the slot controller, and turns them into one interrupt locator word and one interrupt request. Each slot owns a small event latch that slot logic sets with one-cycle pulses and that software clears by writing ones. Each slot also has a disable mask that hides chosen events. A global control word holds the interrupt gates and two sticky detection flags.

Software reads the locator to learn which sources are pending. Bit 0 stands for command completion and bit i+1 for slot i. The request leaves the block in one of two ways. With message signalling off, a level output follows the aggregate state. With it on, the level output stays low, and a one-cycle message-request pulse marks every change of the aggregate state, both when it rises and when it falls.

Top module: `hp_irq_locator`

## Requirements
- R1: Slot i is read and written at word address 2+i. Bits [4:0] of that word are its event latch: bit 0 presence change, bit 1 isolated fault, bit 2 button press, bit 3 retention-latch change, bit 4 connected fault. A pulse on an event input bit sets the matching latch bit.
- R2: Writing 1 to a latch bit clears it, and writing 0 leaves it unchanged. If a set pulse and a clearing write hit the same bit in the same cycle, the bit stays set.
- R3: Bits [14:8] of a slot word are its read/write disable mask. Slot i is pending when some latch bit is 1 and the mask bit at the same position in [4:0] is 0. A pending slot i sets locator bit i+1, and mask bits 5 and 6 have no effect on it.
- R4: Locator bit 0 is 1 exactly when command-detected (control bit 16) is 1 and command-interrupt-disable (control bit 2) is 0.
- R5: The aggregate level is 1 only when global interrupt disable (control bit 0) is 0 and the locator is non-zero. With message signalling off, irq_level equals the aggregate level.
- R6: With msi_en high, irq_level is 0, and msi_req is a one-cycle pulse whenever the aggregate level differs from the level recorded in the previous cycle. The recorded level follows the aggregate level in both modes.
- R7: The control word is at address 0. Bits 0 to 3 are read/write disables. Bit 16 (command-detected) and bit 17 (arbiter-detected) are set by pulses on cmd_done and arb_fault and are cleared by writing 1. The locator reads at address 1.
- R8: After reset the control word reads 0x0000000F, every slot word reads 0x00007F00, and the locator, irq_level and msi_req are 0.
- R9: A write or event accepted at a clock edge is visible in the locator, irq_level and msi_req right after that same edge, and not before it.
- R10: Writes to the locator address or to any unmapped address change no state. Reads from unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Word address of the read |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| evt_set | input | NUM_SLOTS*5 | Event set pulses, 5 bits per slot |
| cmd_done | input | 1 | Command completion pulse |
| arb_fault | input | 1 | Arbiter fault pulse |
| msi_en | input | 1 | Selects message signalling |
| irq_level | output | 1 | Level interrupt |
| msi_req | output | 1 | One-cycle message request |

## Verification
The assertions check on every cycle that an empty locator never raises the level, that the global disable holds the level low, that locator bit 0 appears only with an ungated command flag, and that message pulses line up exactly with changes of the recorded level while the level output stays quiet. Only the bench scenarios can show the per-slot mask arithmetic over all latch and mask patterns, the write-one-to-clear and set-wins ordering, the reset values and the ignored writes, because those depend on register contents seen through the read port.

// File: rtl/hpil_pkg.sv
package hpil_pkg;
   localparam int REG_W      = 32;
   localparam int EVT_W      = 5;
   localparam int MASK_W     = 7;
   localparam int MASK_LSB   = 8;
   localparam int DIS_W      = 4;
   localparam int CTL_IRQ_OFF  = 0;
   localparam int CTL_CMD_OFF  = 2;
   localparam int CTL_CMD_SEEN = 16;
   localparam int CTL_ARB_SEEN = 17;
   localparam int ADR_CTRL   = 0;
   localparam int ADR_LOC    = 1;
   localparam int ADR_SLOT0  = 2;
   localparam logic [MASK_W-1:0] MASK_RST = '1;
   localparam logic [DIS_W-1:0]  DIS_RST  = '1;
endpackage

// File: rtl/hpil_slot_regs.sv
module hpil_slot_regs
   import hpil_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic [EVT_W-1:0]  wr_clr,
   input  logic [MASK_W-1:0] wr_mask,
   input  logic [EVT_W-1:0]  evt_set,
   output logic [EVT_W-1:0]  latch_q,
   output logic [MASK_W-1:0] mask_q,
   output logic              pend_d
);
   logic [EVT_W-1:0]  latch_d;
   logic [MASK_W-1:0] mask_d;

   always_comb begin
      latch_d = latch_q;
      mask_d  = mask_q;
      if (wr_hit) begin
         latch_d = latch_q & ~wr_clr;
         mask_d  = wr_mask;
      end
      latch_d = latch_d | evt_set;
      pend_d  = |(latch_d & ~mask_d[EVT_W-1:0]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
         mask_q  <= MASK_RST;
      end else begin
         latch_q <= latch_d;
         mask_q  <= mask_d;
      end
   end
endmodule

// File: rtl/hpil_ctrl_reg.sv
module hpil_ctrl_reg
   import hpil_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_hit,
   input  logic [DIS_W-1:0] wr_dis,
   input  logic [1:0]       wr_clr_seen,
   input  logic             cmd_done,
   input  logic             arb_fault,
   output logic [DIS_W-1:0] dis_q,
   output logic             cmd_seen_q,
   output logic             arb_seen_q,
   output logic             irq_off_d,
   output logic             cmd_pend_d
);
   logic [DIS_W-1:0] dis_d;
   logic             cmd_seen_d;
   logic             arb_seen_d;

   always_comb begin
      dis_d      = dis_q;
      cmd_seen_d = cmd_seen_q;
      arb_seen_d = arb_seen_q;
      if (wr_hit) begin
         dis_d      = wr_dis;
         cmd_seen_d = cmd_seen_q & ~wr_clr_seen[0];
         arb_seen_d = arb_seen_q & ~wr_clr_seen[1];
      end
      cmd_seen_d = cmd_seen_d | cmd_done;
      arb_seen_d = arb_seen_d | arb_fault;
      irq_off_d  = dis_d[CTL_IRQ_OFF];
      cmd_pend_d = cmd_seen_d & ~dis_d[CTL_CMD_OFF];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dis_q      <= DIS_RST;
         cmd_seen_q <= 1'b0;
         arb_seen_q <= 1'b0;
      end else begin
         dis_q      <= dis_d;
         cmd_seen_q <= cmd_seen_d;
         arb_seen_q <= arb_seen_d;
      end
   end
endmodule

// File: rtl/hpil_irq_combine.sv
module hpil_irq_combine #(
   parameter int NUM_SLOTS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_SLOTS-1:0] slot_pend_d,
   input  logic                 cmd_pend_d,
   input  logic                 irq_off_d,
   input  logic                 msi_en,
   output logic [NUM_SLOTS:0]   locator_q,
   output logic                 level_q,
   output logic                 irq_level,
   output logic                 msi_req
);
   logic [NUM_SLOTS:0] locator_d;
   logic               level_d;

   always_comb begin
      locator_d = {slot_pend_d, cmd_pend_d};
      level_d   = ~irq_off_d & (|locator_d);
   end

   // level_q doubles as the recorded level used for change detection
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locator_q <= '0;
         level_q   <= 1'b0;
         irq_level <= 1'b0;
         msi_req   <= 1'b0;
      end else begin
         locator_q <= locator_d;
         level_q   <= level_d;
         irq_level <= level_d & ~msi_en;
         msi_req   <= msi_en & (level_d ^ level_q);
      end
   end
endmodule

// File: rtl/hp_irq_locator.sv
module hp_irq_locator
   import hpil_pkg::*;
#(
   parameter int NUM_SLOTS = 4,
   parameter int ADDR_W    = 6
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [REG_W-1:0]           wr_data,
   input  logic [ADDR_W-1:0]          rd_addr,
   output logic [REG_W-1:0]           rd_data,
   input  logic [NUM_SLOTS*EVT_W-1:0] evt_set,
   input  logic                       cmd_done,
   input  logic                       arb_fault,
   input  logic                       msi_en,
   output logic                       irq_level,
   output logic                       msi_req
);
   localparam int NUM_REGS = ADR_SLOT0 + NUM_SLOTS;

   if (NUM_SLOTS < 1 || NUM_SLOTS > 31) begin : g_bad_slots
      $error("NUM_SLOTS must lie in 1..31");
   end
   if (NUM_REGS > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for NUM_SLOTS");
   end

   logic [DIS_W-1:0]     ctrl_dis_q;
   logic                 cmd_seen_q;
   logic                 arb_seen_q;
   logic                 irq_off_d;
   logic                 cmd_pend_d;
   logic [NUM_SLOTS-1:0] slot_pend_d;
   logic [NUM_SLOTS:0]   locator_q;
   logic                 level_q;
   logic [REG_W-1:0]     slot_word [NUM_SLOTS];
   logic                 unused_wr_bits;

   assign unused_wr_bits = ^{wr_data[31:18], wr_data[15], wr_data[7:5]};

   hpil_ctrl_reg u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_hit      (wr_en && (wr_addr == ADDR_W'(ADR_CTRL))),
      .wr_dis      (wr_data[DIS_W-1:0]),
      .wr_clr_seen (wr_data[CTL_ARB_SEEN:CTL_CMD_SEEN]),
      .cmd_done    (cmd_done),
      .arb_fault   (arb_fault),
      .dis_q       (ctrl_dis_q),
      .cmd_seen_q  (cmd_seen_q),
      .arb_seen_q  (arb_seen_q),
      .irq_off_d   (irq_off_d),
      .cmd_pend_d  (cmd_pend_d)
   );

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      logic [EVT_W-1:0]  latch_q;
      logic [MASK_W-1:0] mask_q;

      hpil_slot_regs u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_hit  (wr_en && (wr_addr == ADDR_W'(ADR_SLOT0 + i))),
         .wr_clr  (wr_data[EVT_W-1:0]),
         .wr_mask (wr_data[MASK_LSB +: MASK_W]),
         .evt_set (evt_set[i*EVT_W +: EVT_W]),
         .latch_q (latch_q),
         .mask_q  (mask_q),
         .pend_d  (slot_pend_d[i])
      );

      assign slot_word[i] = {16'b0, 1'b0, mask_q, 3'b0, latch_q};
   end

   hpil_irq_combine #(.NUM_SLOTS(NUM_SLOTS)) u_combine (
      .clk         (clk),
      .rst_n       (rst_n),
      .slot_pend_d (slot_pend_d),
      .cmd_pend_d  (cmd_pend_d),
      .irq_off_d   (irq_off_d),
      .msi_en      (msi_en),
      .locator_q   (locator_q),
      .level_q     (level_q),
      .irq_level   (irq_level),
      .msi_req     (msi_req)
   );

   always_comb begin
      rd_data = '0;
      if (rd_addr == ADDR_W'(ADR_CTRL)) begin
         rd_data = {14'b0, arb_seen_q, cmd_seen_q, 12'b0, ctrl_dis_q};
      end else if (rd_addr == ADDR_W'(ADR_LOC)) begin
         rd_data[NUM_SLOTS:0] = locator_q;
      end else begin
         for (int i = 0; i < NUM_SLOTS; i++) begin
            if (rd_addr == ADDR_W'(ADR_SLOT0 + i)) rd_data = slot_word[i];
         end
      end
   end
endmodule

// File: rtl/hpil_chk.sv
module hpil_chk #(
   parameter int NUM_SLOTS = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               msi_en,
   input logic               irq_level,
   input logic               msi_req,
   input logic [NUM_SLOTS:0] locator_q,
   input logic               level_q,
   input logic [3:0]         ctrl_dis_q,
   input logic               cmd_seen_q
);
   // R5
   empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (locator_q == '0) |-> (!irq_level && !level_q));

   // R5
   global_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_dis_q[0] |-> (!level_q && !irq_level));

   // R4
   cmd_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      locator_q[0] |-> (cmd_seen_q && !ctrl_dis_q[2]));

   // R6
   msg_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msi_req == ($past(msi_en) && (level_q != $past(level_q))));

   // R6
   msg_level_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_level |-> !$past(msi_en));
endmodule

bind hp_irq_locator hpil_chk #(.NUM_SLOTS(NUM_SLOTS)) u_hpil_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .msi_en     (msi_en),
   .irq_level  (irq_level),
   .msi_req    (msi_req),
   .locator_q  (locator_q),
   .level_q    (level_q),
   .ctrl_dis_q (ctrl_dis_q),
   .cmd_seen_q (cmd_seen_q)
);

// File: tb/test_hp_irq_locator.sv
`timescale 1ns/1ps
module test_hp_irq_locator;
   localparam int NS = 3;
   localparam int AW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [31:0]   wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [31:0]   rd_data;
   logic [NS*5-1:0] evt_set = '0;
   logic          cmd_done = 1'b0;
   logic          arb_fault = 1'b0;
   logic          msi_en = 1'b0;
   logic          irq_level;
   logic          msi_req;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   hp_irq_locator #(.NUM_SLOTS(NS), .ADDR_W(AW)) i_hp_irq_locator (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .evt_set(evt_set), .cmd_done(cmd_done), .arb_fault(arb_fault),
      .msi_en(msi_en), .irq_level(irq_level), .msi_req(msi_req)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic rd(input int a, output logic [31:0] v);
      rd_addr = AW'(a);
      #1;
      v = rd_data;
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic evt(input int s, input logic [4:0] bits);
      @(negedge clk);
      evt_set = '0;
      evt_set[s*5 +: 5] = bits;
      @(negedge clk);
      evt_set = '0;
   endtask

   task automatic pulse_cmd();
      @(negedge clk);
      cmd_done = 1'b1;
      @(negedge clk);
      cmd_done = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R8 reset state
      rd(0, v); chk("R8 ctrl", v, 32'h0000000F);
      rd(1, v); chk("R8 locator", v, 32'h0);
      for (int s = 0; s < NS; s++) begin
         rd(2 + s, v); chk("R8 slot", v, 32'h00007F00);
      end
      chk("R8 irq", {31'b0, irq_level}, 32'h0);
      chk("R8 msi", {31'b0, msi_req}, 32'h0);

      // R1 each event bit latches; masked by reset value so no locator
      for (int s = 0; s < NS; s++) begin
         for (int b = 0; b < 5; b++) begin
            evt(s, 5'(1 << b));
            rd(2 + s, v); chk("R1 latch bit", v, 32'h7F00 | (32'h1 << b));
            rd(1, v); chk("R3 masked", v, 32'h0);
            wr(2 + s, 32'h7F00 | (32'h1 << b));
            rd(2 + s, v); chk("R2 clear", v, 32'h7F00);
         end
      end

      // R2 zero writes keep, ones clear, set wins
      evt(0, 5'h05);
      wr(2, 32'h7F00);
      rd(2, v); chk("R2 zero keeps", v, 32'h7F05);
      wr(2, 32'h7F01);
      rd(2, v); chk("R2 one clears", v, 32'h7F04);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(2); wr_data = 32'h7F04;
      evt_set = 15'h0004;
      @(negedge clk);
      wr_en = 1'b0; evt_set = '0;
      rd(2, v); chk("R2 set wins", v, 32'h7F04);
      wr(2, 32'h7F1F);

      // R3/R5 sweep of latch and mask patterns, global irq on, cmd gated
      wr(0, 32'h0000000E);
      for (int s = 0; s < NS; s++) begin
         for (int m = 0; m < 32; m++) begin
            for (int p = 0; p < 32; p++) begin
               logic [31:0] mw;
               logic pend;
               mw = {16'b0, 1'b0, 2'(p % 4), 5'(m), 8'h1F};
               wr(2 + s, mw);
               evt(s, 5'(p));
               pend = ((p & ~m) & 5'h1F) != 0;
               rd(1, v); chk("R3 locator", v, 32'(pend) << (s + 1));
               chk("R5 level", {31'b0, irq_level}, {31'b0, pend});
               rd(2 + s, v); chk("R1 readback", v, {16'b0, 1'b0, 2'(p % 4), 5'(m), 3'b0, 5'(p)});
            end
         end
         wr(2 + s, 32'h7F1F);
      end

      // R7 control word
      wr(0, 32'h0000000F);
      pulse_cmd();
      rd(0, v); chk("R7 cmd seen", v, 32'h0001000F);
      @(negedge clk); arb_fault = 1'b1; @(negedge clk); arb_fault = 1'b0;
      rd(0, v); chk("R7 arb seen", v, 32'h0003000F);
      wr(0, 32'h00010000);
      rd(0, v); chk("R7 w1c cmd", v, 32'h00020000);
      wr(0, 32'h00020005);
      rd(0, v); chk("R7 w1c arb rw", v, 32'h00000005);
      wr(0, 32'h0);

      // R4 command bit
      pulse_cmd();
      rd(1, v); chk("R4 cmd locator", v, 32'h1);
      chk("R5 cmd level", {31'b0, irq_level}, 32'h1);
      wr(0, 32'h4);
      rd(1, v); chk("R4 cmd gated", v, 32'h0);
      chk("R5 gated level", {31'b0, irq_level}, 32'h0);
      rd(0, v); chk("R4 flag kept", v, 32'h00010004);
      wr(0, 32'h1);
      rd(1, v); chk("R4 ungated", v, 32'h1);
      chk("R5 global off", {31'b0, irq_level}, 32'h0);
      wr(0, 32'h00010000);
      rd(1, v); chk("R4 cleared", v, 32'h0);

      // R10 ignored writes and unmapped reads
      pulse_cmd();
      wr(1, 32'h0);
      rd(1, v); chk("R10 locator write ignored", v, 32'h1);
      wr(NS + 2, 32'hFFFFFFFF);
      wr(63, 32'hFFFFFFFF);
      rd(0, v); chk("R10 ctrl intact", v, 32'h00010000);
      for (int s = 0; s < NS; s++) begin
         rd(2 + s, v); chk("R10 slot intact", v, 32'h00007F00);
      end
      rd(NS + 2, v); chk("R10 unmapped read", v, 32'h0);
      rd(63, v); chk("R10 top read", v, 32'h0);
      wr(0, 32'h00010000);

      // R6 message mode, R9 timing
      @(negedge clk); msi_en = 1'b1;
      @(negedge clk);
      cmd_done = 1'b1;
      #1;
      chk("R9 before edge", {31'b0, msi_req}, 32'h0);
      @(negedge clk); cmd_done = 1'b0;
      chk("R6 rise pulse", {31'b0, msi_req}, 32'h1);
      chk("R6 level quiet", {31'b0, irq_level}, 32'h0);
      @(negedge clk);
      chk("R6 pulse width", {31'b0, msi_req}, 32'h0);
      wr(0, 32'h00010000);
      chk("R6 fall pulse", {31'b0, msi_req}, 32'h1);
      @(negedge clk);
      chk("R6 fall width", {31'b0, msi_req}, 32'h0);
      wr(0, 32'h0);
      chk("R6 no change", {31'b0, msi_req}, 32'h0);
      @(negedge clk); msi_en = 1'b0;
      pulse_cmd();
      chk("R5 level mode", {31'b0, irq_level}, 32'h1);
      chk("R6 no msg off", {31'b0, msi_req}, 32'h0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule